// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block runs the refill of one cache line after a miss. It sits between the miss handler and a burst memory port. It takes the word address of the missed access and asks memory for the whole 64-byte line in a single wrapping burst. Each returned beat is written into its own slot of the line buffer. The processor stall is lifted in the cycle its 64-bit word is forwarded, so the processor does not wait for the rest of the line.

Two orderings are supported and are chosen for each miss. In critical-first order the burst starts at the beat that holds the missed word and wraps around the line. In early-restart order the burst starts at beat 0 and runs upward, and the processor is still released as soon as the beat holding its word arrives. A second per-miss input sets the memory beat width to 64 or 128 bits. That choice gives eight or four beats per line.

Top module: `cwf_refill`

## Requirements
- R1: After reset, miss_ready is 1, while mem_req_valid, mem_rready, fill_we, line_done, cpu_stall and cpu_word_valid are all 0.
- R2: A miss is taken when miss_valid and miss_ready are both 1, and miss_ready is 1 only while no refill is running. In the cycle after a miss is taken, cpu_stall is 1 and miss_ready is 0. mode_cwf (1 = critical-first, 0 = early restart) and wide_sel (1 = 128-bit beats, 0 = 64-bit beats) are sampled in that same cycle.
- R3: In the cycle after a miss is taken, exactly one burst request is presented, and it is held until mem_req_ready. mem_req_addr is the line base (byte address with the low 6 bits cleared) plus start_beat times the beat size in bytes. start_beat is the critical beat in critical-first mode and 0 in early-restart mode. Memory returns the beats wrapping from start_beat.
- R4: With wide_sel=0 a line is 8 beats and the critical beat is word-offset bits [2:0] of miss_waddr. With wide_sel=1 a line is 4 beats and the critical beat is word-offset bits [2:1].
- R5: The k-th accepted beat (k counted from 0) is written to slot (start_beat + k) mod beats. In the cycle after the beat is accepted, fill_we bit [slot] is 1 and no other bit is set, and fill_data carries the beat. With 64-bit beats, fill_data bits [127:64] are 0.
- R6: cpu_word_valid pulses for one cycle, in the cycle after the beat holding the missed word is accepted. cpu_word is then that word. With 128-bit beats, the word is the upper half when word-offset bit 0 is 1 and the lower half when it is 0.
- R7: cpu_stall falls in the same cycle that cpu_word_valid rises, and it stays 0 until the next miss is taken.
- R8: line_done pulses in the same cycle as the fill write of the last beat of the burst. miss_ready is 1 in that cycle.
- R9: mem_rready is 1 only after the request has been accepted and before the last beat. Any number of wait cycles between beats leaves the order and the forwarded word unchanged, and no fill write happens in a wait cycle.
- R10: In critical-first mode the forwarded word arrives with the first fill write of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request |
| miss_ready | output | 1 | Sequencer idle, miss can be taken |
| miss_waddr | input | 29 | Word (8-byte) address of the missed access |
| mode_cwf | input | 1 | 1 = critical-first order, 0 = early restart |
| wide_sel | input | 1 | 1 = 128-bit memory beats, 0 = 64-bit beats |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted by memory |
| mem_req_addr | output | 32 | Byte address of the first beat of the burst |
| mem_rvalid | input | 1 | Return beat valid |
| mem_rready | output | 1 | Sequencer accepts return beats |
| mem_rdata | input | 128 | Return beat data (low 64 bits used for narrow beats) |
| fill_we | output | 8 | One-hot write enable of line buffer slot |
| fill_data | output | 128 | Data for the enabled slot |
| line_done | output | 1 | Last slot of the line written |
| cpu_stall | output | 1 | Processor held waiting for its word |
| cpu_word_valid | output | 1 | Missed word forwarded this cycle |
| cpu_word | output | 64 | The forwarded word |

## Verification
The sweep covers every word offset inside the line for both orderings and both beat widths. This separates the wrap start, the critical-beat selection and the lane selection for wide beats. Each combination runs once with beats back to back and once with uneven wait cycles between beats and a delayed request accept. This shows that slot order and release depend on beat count, not on cycle count. The early-restart runs with the missed word in the last beat check the case where release and line completion fall in one cycle. Narrow beats are driven with junk in the upper half of mem_rdata, which shows the masking of fill_data.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } refill_state_e;

  // beats needed to move one line over a port of beat_bits
  function automatic int unsigned beats_in_line(input int unsigned line_bytes,
                                                input int unsigned beat_bits);
    return (line_bytes * 8) / beat_bits;
  endfunction

  // beat that holds a given word of the line
  function automatic int unsigned crit_slot(input int unsigned word_off,
                                            input int unsigned word_bits,
                                            input int unsigned beat_bits);
    return word_off / (beat_bits / word_bits);
  endfunction

  // position of the word inside its beat
  function automatic int unsigned lane_of(input int unsigned word_off,
                                          input int unsigned word_bits,
                                          input int unsigned beat_bits);
    return word_off % (beat_bits / word_bits);
  endfunction

  // slot written by the k-th beat of a burst wrapping from start (beats is a power of two)
  function automatic int unsigned wrap_slot(input int unsigned start,
                                            input int unsigned k,
                                            input int unsigned beats);
    return (start + k) & (beats - 1);
  endfunction

endpackage

// File: rtl/cwf_order_gen.sv
module cwf_order_gen #(
  parameter int BEAT_IW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [BEAT_IW-1:0] start,
  input  logic [BEAT_IW-1:0] last_idx,
  output logic [BEAT_IW-1:0] slot,
  output logic               last
);

  logic [BEAT_IW-1:0] beat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
    end else if (load) begin
      beat_cnt <= '0;
    end else if (step) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  assign slot = BEAT_IW'(cwf_pkg::wrap_slot(32'(start), 32'(beat_cnt), 32'(last_idx) + 1));
  assign last = (beat_cnt == last_idx);

endmodule

// File: rtl/cwf_fill_port.sv
module cwf_fill_port #(
  parameter int MAX_BEATS = 8,
  parameter int BEAT_IW   = 3,
  parameter int DATA_W    = 128,
  parameter int NARROW_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 last,
  input  logic                 wide,
  input  logic [BEAT_IW-1:0]   slot,
  input  logic [DATA_W-1:0]    rdata,
  output logic [MAX_BEATS-1:0] fill_we,
  output logic [DATA_W-1:0]    fill_data,
  output logic                 line_done
);

  logic [MAX_BEATS-1:0] we_next;
  logic [DATA_W-1:0]    data_next;

  for (genvar i = 0; i < MAX_BEATS; i++) begin : g_slot_we
    assign we_next[i] = step && (slot == BEAT_IW'(i));
  end

  assign data_next = wide ? rdata : {{(DATA_W-NARROW_W){1'b0}}, rdata[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_we   <= '0;
      fill_data <= '0;
      line_done <= 1'b0;
    end else begin
      fill_we   <= we_next;
      line_done <= step && last;
      if (step) begin
        fill_data <= data_next;
      end
    end
  end

endmodule

// File: rtl/cwf_cpu_fwd.sv
module cwf_cpu_fwd #(
  parameter int DATA_W  = 128,
  parameter int WORD_W  = 64,
  parameter int LANE_IW = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_fire,
  input  logic               fwd_fire,
  input  logic [LANE_IW-1:0] lane_idx,
  input  logic [DATA_W-1:0]  rdata,
  output logic               cpu_word_valid,
  output logic [WORD_W-1:0]  cpu_word,
  output logic               cpu_stall
);

  localparam int LANES = DATA_W / WORD_W;

  logic [WORD_W-1:0] lane_word [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_word[j] = rdata[j*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_word_valid <= 1'b0;
      cpu_word       <= '0;
      cpu_stall      <= 1'b0;
    end else begin
      cpu_word_valid <= fwd_fire;
      if (fwd_fire) begin
        cpu_word <= lane_word[lane_idx];
      end
      if (miss_fire) begin
        cpu_stall <= 1'b1;
      end else if (fwd_fire) begin
        cpu_stall <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NARROW_W   = 64,
  parameter int WIDE_W     = 128,
  parameter int WORD_W     = 64
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    miss_valid,
  output logic                                    miss_ready,
  input  logic [ADDR_W-$clog2(WORD_W/8)-1:0]      miss_waddr,
  input  logic                                    mode_cwf,
  input  logic                                    wide_sel,
  output logic                                    mem_req_valid,
  input  logic                                    mem_req_ready,
  output logic [ADDR_W-1:0]                       mem_req_addr,
  input  logic                                    mem_rvalid,
  output logic                                    mem_rready,
  input  logic [WIDE_W-1:0]                       mem_rdata,
  output logic [(LINE_BYTES*8/NARROW_W)-1:0]      fill_we,
  output logic [WIDE_W-1:0]                       fill_data,
  output logic                                    line_done,
  output logic                                    cpu_stall,
  output logic                                    cpu_word_valid,
  output logic [WORD_W-1:0]                       cpu_word
);

  import cwf_pkg::*;

  localparam int WORD_SH   = $clog2(WORD_W / 8);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int WOFF_W    = OFF_W - WORD_SH;
  localparam int WADDR_W   = ADDR_W - WORD_SH;
  localparam int NB        = beats_in_line(LINE_BYTES, NARROW_W);
  localparam int WB        = beats_in_line(LINE_BYTES, WIDE_W);
  localparam int MAX_BEATS = NB;
  localparam int BEAT_IW   = $clog2(MAX_BEATS);
  localparam int NSH       = $clog2(NARROW_W / 8);
  localparam int WSH       = $clog2(WIDE_W / 8);
  localparam int LANES     = WIDE_W / WORD_W;
  localparam int LANE_IW   = (LANES > 1) ? $clog2(LANES) : 1;

  refill_state_e state;

  logic [WADDR_W-WOFF_W-1:0] cap_line;
  logic [WOFF_W-1:0]         cap_woff;
  logic                      cap_mode;
  logic                      cap_wide;

  // named events for the checker
  logic                miss_fire;
  logic                beat_fire;
  logic                crit_hit;
  logic                last_beat;
  logic [BEAT_IW-1:0]  cur_slot;

  logic [BEAT_IW-1:0]  crit_n, crit_w, crit_beat;
  logic [BEAT_IW-1:0]  start_beat, last_idx;
  logic [OFF_W-1:0]    req_off;
  logic [LANE_IW-1:0]  lane_n, lane_w, lane_idx;

  assign miss_ready    = (state == ST_IDLE);
  assign miss_fire     = miss_valid && miss_ready;
  assign mem_req_valid = (state == ST_REQ);
  assign mem_rready    = (state == ST_DATA);
  assign beat_fire     = mem_rvalid && mem_rready;

  // critical beat and lane for both beat widths, then pick the active one
  assign crit_n    = BEAT_IW'(crit_slot(32'(cap_woff), WORD_W, NARROW_W));
  assign crit_w    = BEAT_IW'(crit_slot(32'(cap_woff), WORD_W, WIDE_W));
  assign crit_beat = cap_wide ? crit_w : crit_n;
  assign lane_n    = LANE_IW'(lane_of(32'(cap_woff), WORD_W, NARROW_W));
  assign lane_w    = LANE_IW'(lane_of(32'(cap_woff), WORD_W, WIDE_W));
  assign lane_idx  = cap_wide ? lane_w : lane_n;

  assign last_idx   = cap_wide ? BEAT_IW'(WB - 1) : BEAT_IW'(NB - 1);
  assign start_beat = cap_mode ? crit_beat : '0;
  assign req_off    = cap_wide ? OFF_W'(32'(start_beat) << WSH)
                               : OFF_W'(32'(start_beat) << NSH);
  assign mem_req_addr = {cap_line, req_off};

  assign crit_hit = (cur_slot == crit_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cap_line <= '0;
      cap_woff <= '0;
      cap_mode <= 1'b0;
      cap_wide <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (miss_valid) begin
            state    <= ST_REQ;
            cap_line <= miss_waddr[WADDR_W-1:WOFF_W];
            cap_woff <= miss_waddr[WOFF_W-1:0];
            cap_mode <= mode_cwf;
            cap_wide <= wide_sel;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (beat_fire && last_beat) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  cwf_order_gen #(
    .BEAT_IW (BEAT_IW)
  ) u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (miss_fire),
    .step     (beat_fire),
    .start    (start_beat),
    .last_idx (last_idx),
    .slot     (cur_slot),
    .last     (last_beat)
  );

  cwf_fill_port #(
    .MAX_BEATS (MAX_BEATS),
    .BEAT_IW   (BEAT_IW),
    .DATA_W    (WIDE_W),
    .NARROW_W  (NARROW_W)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (beat_fire),
    .last      (last_beat),
    .wide      (cap_wide),
    .slot      (cur_slot),
    .rdata     (mem_rdata),
    .fill_we   (fill_we),
    .fill_data (fill_data),
    .line_done (line_done)
  );

  cwf_cpu_fwd #(
    .DATA_W  (WIDE_W),
    .WORD_W  (WORD_W),
    .LANE_IW (LANE_IW)
  ) u_fwd (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_fire      (miss_fire),
    .fwd_fire       (beat_fire && crit_hit),
    .lane_idx       (lane_idx),
    .rdata          (mem_rdata),
    .cpu_word_valid (cpu_word_valid),
    .cpu_word       (cpu_word),
    .cpu_stall      (cpu_stall)
  );

endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int MAX_BEATS  = 8,
  parameter int WIDE_BEATS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 miss_valid,
  input logic                 miss_ready,
  input logic                 wide_sel,
  input logic                 mem_req_valid,
  input logic                 mem_rready,
  input logic [MAX_BEATS-1:0] fill_we,
  input logic                 line_done,
  input logic                 cpu_stall,
  input logic                 cpu_word_valid,
  input logic                 beat_fire,
  input logic                 crit_hit
);

  localparam int CNT_W = $clog2(MAX_BEATS) + 1;

  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] line_beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt     <= '0;
      line_beats <= CNT_W'(MAX_BEATS);
    end else if (miss_valid && miss_ready) begin
      wr_cnt     <= '0;
      line_beats <= wide_sel ? CNT_W'(WIDE_BEATS) : CNT_W'(MAX_BEATS);
    end else if (fill_we != '0) begin
      wr_cnt <= wr_cnt + 1'b1;
    end
  end

  p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we));

  p_stall_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (cpu_stall && !miss_ready));

  p_crit_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && crit_hit) |=> cpu_word_valid);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_word_valid |-> !cpu_stall);

  p_stall_stays_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stall && !(miss_valid && miss_ready)) |=> !cpu_stall);

  p_idle_unstalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !cpu_stall);

  p_done_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> ((wr_cnt + 1'b1) == line_beats));

  p_ready_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> miss_ready);

  p_phase_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rready));

endmodule

bind cwf_refill cwf_refill_chk #(
  .MAX_BEATS  (MAX_BEATS),
  .WIDE_BEATS (WB)
) u_cwf_refill_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .miss_valid     (miss_valid),
  .miss_ready     (miss_ready),
  .wide_sel       (wide_sel),
  .mem_req_valid  (mem_req_valid),
  .mem_rready     (mem_rready),
  .fill_we        (fill_we),
  .line_done      (line_done),
  .cpu_stall      (cpu_stall),
  .cpu_word_valid (cpu_word_valid),
  .beat_fire      (beat_fire),
  .crit_hit       (crit_hit)
);

// File: tb/test_cwf_refill.sv
`timescale 1ns/1ps
module test_cwf_refill;

  localparam int CLK_NS = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic         miss_ready;
  logic [28:0]  miss_waddr = '0;
  logic         mode_cwf = 1'b0;
  logic         wide_sel = 1'b0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rvalid = 1'b0;
  logic         mem_rready;
  logic [127:0] mem_rdata = '0;
  logic [7:0]   fill_we;
  logic [127:0] fill_data;
  logic         line_done;
  logic         cpu_stall;
  logic         cpu_word_valid;
  logic [63:0]  cpu_word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cwf_refill i_cwf_refill (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_waddr(miss_waddr),
    .mode_cwf(mode_cwf), .wide_sel(wide_sel),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata),
    .fill_we(fill_we), .fill_data(fill_data), .line_done(line_done),
    .cpu_stall(cpu_stall), .cpu_word_valid(cpu_word_valid), .cpu_word(cpu_word)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(input int tag, input int w);
    return {16'hC0DE, 16'(tag), 29'h0, 3'(w)};
  endfunction

  // memory image of one beat: narrow beats carry junk in the upper half
  function automatic logic [127:0] beat_of(input int tag, input int slot, input bit wide);
    if (wide) return {word_of(tag, 2*slot+1), word_of(tag, 2*slot)};
    return {64'hBAD0_BAD0_BAD0_BAD0, word_of(tag, slot)};
  endfunction

  task automatic run_miss(input int woff, input bit mode, input bit wide,
                          input bit gappy, input int req_delay, input int tag);
    int  nbeats   = wide ? 4 : 8;
    int  crit     = wide ? woff / 2 : woff;
    int  start    = mode ? crit : 0;
    int  bbytes   = wide ? 16 : 8;
    logic [31:0] line_base = 32'h0001_0000 + 32'(tag) * 64;
    logic [31:0] exp_addr  = line_base + 32'(start * bbytes);
    bit  released = 1'b0;

    check(miss_ready == 1'b1, "R2 idle before miss", 128'(miss_ready), 128'd1);
    miss_valid = 1'b1;
    miss_waddr = 29'(line_base >> 3) + 29'(woff);
    mode_cwf   = mode;
    wide_sel   = wide;
    @(negedge clk);
    miss_valid = 1'b0;
    mode_cwf   = ~mode;
    wide_sel   = ~wide;
    check(cpu_stall == 1'b1, "R2 stall after miss", 128'(cpu_stall), 128'd1);
    check(miss_ready == 1'b0, "R2 busy after miss", 128'(miss_ready), 128'd0);
    check(mem_req_valid == 1'b1, "R3 request raised", 128'(mem_req_valid), 128'd1);
    check(mem_req_addr == exp_addr, "R3 R4 request address", 128'(mem_req_addr), 128'(exp_addr));
    check(mem_rready == 1'b0, "R9 no rready in request phase", 128'(mem_rready), 128'd0);
    for (int d = 0; d < req_delay; d++) begin
      @(negedge clk);
      check(mem_req_valid == 1'b1 && mem_req_addr == exp_addr, "R3 request held",
            128'(mem_req_addr), 128'(exp_addr));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(mem_req_valid == 1'b0 && mem_rready == 1'b1, "R9 data phase",
          {126'd0, mem_req_valid, mem_rready}, 128'd1);

    for (int k = 0; k < nbeats; k++) begin
      int gaps = gappy ? (k + woff) % 3 : 0;
      int slot = (start + k) % nbeats;
      logic [127:0] exp_data;
      for (int g = 0; g < gaps; g++) begin
        mem_rvalid = 1'b0;
        mem_rdata  = '1;
        @(negedge clk);
        check(fill_we == 8'h00, "R9 no write in wait cycle", 128'(fill_we), 128'd0);
        check(cpu_stall == !released, "R7 stall in wait cycle", 128'(cpu_stall), 128'(!released));
      end
      mem_rvalid = 1'b1;
      mem_rdata  = beat_of(tag, slot, wide);
      @(negedge clk);
      exp_data = wide ? mem_rdata : {64'd0, mem_rdata[63:0]};
      check(fill_we == 8'(1 << slot), "R5 slot enable", 128'(fill_we), 128'(1 << slot));
      check(fill_data == exp_data, "R5 fill data", fill_data, exp_data);
      if (slot == crit) begin
        check(cpu_word_valid == 1'b1, "R6 forward pulse", 128'(cpu_word_valid), 128'd1);
        check(cpu_word == word_of(tag, woff), "R6 forwarded word", 128'(cpu_word),
              128'(word_of(tag, woff)));
        check(cpu_stall == 1'b0, "R7 stall drops with forward", 128'(cpu_stall), 128'd0);
        released = 1'b1;
      end else begin
        check(cpu_word_valid == 1'b0, "R6 no forward on other beat", 128'(cpu_word_valid), 128'd0);
        check(cpu_stall == !released, "R7 stall level", 128'(cpu_stall), 128'(!released));
      end
      if (k == 0 && mode)
        check(cpu_word_valid == 1'b1, "R10 critical word first", 128'(cpu_word_valid), 128'd1);
      check(line_done == (k == nbeats - 1), "R8 line done timing", 128'(line_done),
            128'(k == nbeats - 1));
      if (k == nbeats - 1)
        check(miss_ready == 1'b1, "R8 ready at line done", 128'(miss_ready), 128'd1);
    end
    mem_rvalid = 1'b0;
    @(negedge clk);
    check(fill_we == 8'h00 && line_done == 1'b0 && cpu_word_valid == 1'b0,
          "R8 quiet after line", {118'd0, fill_we, line_done, cpu_word_valid}, 128'd0);
    check(cpu_stall == 1'b0 && mem_rready == 1'b0, "R9 idle after line",
          {126'd0, cpu_stall, mem_rready}, 128'd0);
  endtask

  initial begin
    int tag = 1;
    repeat (3) @(negedge clk);
    check(miss_ready == 1'b1 && mem_req_valid == 1'b0 && mem_rready == 1'b0,
          "R1 reset handshake", {125'd0, miss_ready, mem_req_valid, mem_rready}, 128'h4);
    check(fill_we == 8'h00 && line_done == 1'b0, "R1 reset fill",
          {119'd0, fill_we, line_done}, 128'd0);
    check(cpu_stall == 1'b0 && cpu_word_valid == 1'b0, "R1 reset cpu",
          {126'd0, cpu_stall, cpu_word_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int g = 0; g < 2; g++)
          for (int off = 0; off < 8; off++) begin
            run_miss(off, m[0], w[0], g[0], (off + g) % 3, tag);
            tag++;
          end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule